// File: doc/BRIEF.md
# Real-Time Clock Offset Correction Scheduler

This block trims the length of selected seconds in a real-time clock without touching the oscillator. It watches the time-of-day positions delivered by the clock counters and, at fixed points in the schedule, asks the prescaler either to insert extra clock pulses or to drop pulses. A 7-bit two's-complement offset sets how many corrections one burst contains, from -64 to +63. Each unit is worth about 4.34 ppm in the hourly scheme and about 4.069 ppm in the fast scheme.

Two schedules exist. In the hourly scheme (mode 0) a burst opens at second 00 of minute 00 of every even hour. One correction then lands at second 00 of each minute. A burst longer than 60 runs on into the next hour. In the fast scheme (mode 1) a burst opens at second 00 of every minute that is a multiple of four. One correction then lands in each second. Whatever is left when second 59 arrives is issued in that second, on consecutive prescaler ticks. An optional interrupt marks every correction.

Internally a four-state controller sequences each burst. IDLE waits for a burst start. On a start it latches the magnitude, sign and mode, then goes to FIRE. FIRE emits one correction on the next prescaler tick. After that it moves to ARMED, or to IDLE when the count reaches zero. ARMED waits for the next slot strobe. It goes to FIRE, or to DRAIN when the slot is second 59 in the fast scheme. DRAIN emits one correction per tick until the count reaches zero, then returns to IDLE.

Top module: `rtc_offset_corrector`

## Requirements
- R1: After reset all three outputs are low and no burst is pending.
- R2: A positive offset (bit 6 clear) produces only add requests. A negative offset (bit 6 set) produces only skip requests. The two requests are never high together.
- R3: An offset of zero produces no requests and no interrupts.
- R4: A burst starts only on a seconds strobe with second 0. In mode 0 this also needs minute 0 and an even hour. In mode 1 it needs a minute divisible by 4. Strobes anywhere else start nothing.
- R5: In mode 0 with magnitude n of 60 or less, exactly one correction is issued at second 0 of minutes 0 to n-1 of the start hour.
- R6: In mode 0 with magnitude 61 to 64, all 60 minutes of the start hour carry one correction each. Minutes 0 to n-61 of the following hour also carry one correction each.
- R7: In mode 1 with magnitude n of 60 or less, seconds 0 to n-1 of the start minute each carry exactly one correction.
- R8: In mode 1 with magnitude above 60, seconds 0 to 58 each carry one correction. Second 59 carries n-59 corrections, on consecutive prescaler ticks.
- R9: A correction request is high for exactly one clock cycle. It appears in the cycle after the first prescaler tick that follows the slot's seconds strobe.
- R10: In mode 0, with interrupts enabled, each correction raises the interrupt for TICK_HZ/64 prescaler tick periods (1/64 s). The interrupt starts in the same cycle as the request.
- R11: In mode 1, with interrupts enabled, the interrupt is a single-cycle strobe that coincides with each request.
- R12: With the interrupt enable low, the interrupt output stays low while corrections are still issued.
- R13: Offset and mode are captured at the burst start. Changes made during a burst do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler clock-enable tick |
| sec_start_i | input | 1 | One-cycle strobe: a new second begins; positions are valid |
| sec_i | input | 6 | Current second, binary 0..59 |
| min_i | input | 6 | Current minute, binary 0..59 |
| hour_i | input | 5 | Current hour, binary 0..23 |
| offset_i | input | 7 | Correction count, two's complement |
| mode_i | input | 1 | 0: hourly scheme, 1: fast scheme |
| irq_en_i | input | 1 | Correction interrupt enable |
| add_req_o | output | 1 | Request to insert one prescaler pulse |
| skip_req_o | output | 1 | Request to remove one prescaler pulse |
| corr_irq_o | output | 1 | Correction interrupt |

## Verification
A seconds strobe moves the controller in the cycle after it. A request is due one clock after the first following tick. The mode-0 interrupt then stays high for TICK_HZ/64 tick periods. The bench drives all inputs on falling edges and samples outputs on falling edges, so every registered result is read half a cycle after the edge that sets it. Each slot is followed by eight ticks, so even a five-pulse drain in second 59 is finished and counted before the next strobe. The latency check places its samples on the exact falling edges just before, at and just after the expected request cycle.

// File: rtl/rtc_ofs_pkg.sv
package rtc_ofs_pkg;

    // time position widths (binary counters)
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    // last second of a minute; fast scheme packs leftovers here
    localparam int LAST_SEC = 59;
    // fast-scheme burst period in minutes is 2**GRP_LOG2
    localparam int GRP_LOG2 = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2,
        ST_DRAIN = 2'd3
    } corr_state_e;

endpackage

// File: rtl/rtc_ofs_slot.sv
module rtc_ofs_slot
    import rtc_ofs_pkg::*;
#(
    parameter int OFS_W = 7
) (
    input  logic             sec_start_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [MIN_W-1:0] min_i,
    input  logic [HR_W-1:0]  hour_i,
    input  logic             mode_i,
    input  logic             mode_lat_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic             burst_start_o,
    output logic             slot_o,
    output logic             slot_last_o
);

    localparam logic [MIN_W-1:0] GRP_MASK = MIN_W'((1 << GRP_LOG2) - 1);

    logic top_of_minute;
    logic group_minute;
    logic even_hour_top;

    always_comb begin
        top_of_minute = (sec_i == '0);
        group_minute  = ((min_i & GRP_MASK) == '0);
        even_hour_top = (min_i == '0) && ((hour_i & HR_W'(1)) == '0);
        burst_start_o = sec_start_i && top_of_minute && (offset_i != '0)
                        && (mode_i ? group_minute : even_hour_top);
        slot_o        = sec_start_i && (mode_lat_i || top_of_minute);
        slot_last_o   = mode_lat_i && (sec_i == SEC_W'(LAST_SEC));
    end

endmodule

// File: rtl/rtc_ofs_fsm.sv
module rtc_ofs_fsm
    import rtc_ofs_pkg::*;
#(
    parameter int OFS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             burst_start_i,
    input  logic             slot_i,
    input  logic             slot_last_i,
    input  logic [OFS_W-1:0] offset_i,
    input  logic             mode_i,
    output logic             emit_o,
    output logic             dir_add_o,
    output logic             mode_lat_o
);

    corr_state_e      state_q, state_d;
    logic [OFS_W-1:0] rem_q, rem_d, mag;
    logic             dir_q, dir_d;
    logic             mode_q, mode_d;

    // magnitude of the two's-complement offset (-min fits unsigned)
    always_comb mag = offset_i[OFS_W-1] ? (~offset_i + 1'b1) : offset_i;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        dir_d   = dir_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_IDLE: begin
                if (burst_start_i) begin
                    state_d = ST_FIRE;
                    rem_d   = mag;
                    dir_d   = !offset_i[OFS_W-1];
                    mode_d  = mode_i;
                end
            end
            ST_ARMED: begin
                if (slot_i) begin
                    state_d = slot_last_i ? ST_DRAIN : ST_FIRE;
                end
            end
            ST_FIRE, ST_DRAIN: begin
                if (tick_i) begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == OFS_W'(1)) begin
                        state_d = ST_IDLE;
                    end else if (state_q == ST_FIRE) begin
                        state_d = ST_ARMED;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            dir_q   <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            dir_q   <= dir_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        emit_o     = tick_i && ((state_q == ST_FIRE) || (state_q == ST_DRAIN));
        dir_add_o  = dir_q;
        mode_lat_o = mode_q;
    end

    // R1
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (rem_q != '0));

    // R5
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_o |=> (rem_q == OFS_W'($past(rem_q) - 1'b1)));

    // R13
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
            |-> ($stable(dir_q) && $stable(mode_q)));

endmodule

// File: rtl/rtc_ofs_pulse.sv
module rtc_ofs_pulse #(
    parameter int HOLD_TICKS = 16,
    parameter int HOLD_W     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic emit_i,
    input  logic dir_add_i,
    input  logic mode_lat_i,
    input  logic irq_en_i,
    output logic add_req_o,
    output logic skip_req_o,
    output logic corr_irq_o
);

    logic              add_q, skip_q, strobe_q;
    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            add_q    <= 1'b0;
            skip_q   <= 1'b0;
            strobe_q <= 1'b0;
            hold_q   <= '0;
        end else begin
            add_q    <= emit_i && dir_add_i;
            skip_q   <= emit_i && !dir_add_i;
            strobe_q <= emit_i && irq_en_i && mode_lat_i;
            if (emit_i && irq_en_i && !mode_lat_i) begin
                hold_q <= HOLD_W'(HOLD_TICKS);
            end else if (tick_i && hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    always_comb begin
        add_req_o  = add_q;
        skip_req_o = skip_q;
        corr_irq_o = strobe_q || (hold_q != '0);
    end

    // R2
    excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_req_o && skip_req_o));

    // R9
    req_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_req_o || skip_req_o) |-> $past(tick_i));

    // R10
    irq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(corr_irq_o) |-> (add_req_o || skip_req_o));

    // R11
    fast_irq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && !emit_i) |=> !strobe_q);

endmodule

// File: rtl/rtc_offset_corrector.sv
module rtc_offset_corrector
    import rtc_ofs_pkg::*;
#(
    parameter int TICK_HZ = 1024,
    parameter int OFS_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sec_start_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [MIN_W-1:0] min_i,
    input  logic [HR_W-1:0]  hour_i,
    input  logic [OFS_W-1:0] offset_i,
    input  logic             mode_i,
    input  logic             irq_en_i,
    output logic             add_req_o,
    output logic             skip_req_o,
    output logic             corr_irq_o
);

    // 1/64 s expressed in prescaler ticks, at least one
    localparam int HOLD_TICKS = (TICK_HZ / 64 > 0) ? TICK_HZ / 64 : 1;
    localparam int HOLD_W     = $clog2(HOLD_TICKS + 1);

    logic burst_start, slot, slot_last;
    logic emit, dir_add, mode_lat;

    rtc_ofs_slot #(.OFS_W(OFS_W)) u_slot (
        .sec_start_i   (sec_start_i),
        .sec_i         (sec_i),
        .min_i         (min_i),
        .hour_i        (hour_i),
        .mode_i        (mode_i),
        .mode_lat_i    (mode_lat),
        .offset_i      (offset_i),
        .burst_start_o (burst_start),
        .slot_o        (slot),
        .slot_last_o   (slot_last)
    );

    rtc_ofs_fsm #(.OFS_W(OFS_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .burst_start_i (burst_start),
        .slot_i        (slot),
        .slot_last_i   (slot_last),
        .offset_i      (offset_i),
        .mode_i        (mode_i),
        .emit_o        (emit),
        .dir_add_o     (dir_add),
        .mode_lat_o    (mode_lat)
    );

    rtc_ofs_pulse #(.HOLD_TICKS(HOLD_TICKS), .HOLD_W(HOLD_W)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .emit_i     (emit),
        .dir_add_i  (dir_add),
        .mode_lat_i (mode_lat),
        .irq_en_i   (irq_en_i),
        .add_req_o  (add_req_o),
        .skip_req_o (skip_req_o),
        .corr_irq_o (corr_irq_o)
    );

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!irq_en_i) && !irq_en_i && $fell(add_req_o || skip_req_o))
            |-> !corr_irq_o || $past(corr_irq_o));

endmodule

// File: tb/test_rtc_offset_corrector.sv
module test_rtc_offset_corrector;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, tick, sec_start, mode, irq_en;
    logic [5:0] sec, min;
    logic [4:0] hour;
    logic [6:0] offset;
    logic       add_req, skip_req, corr_irq;

    rtc_offset_corrector #(.TICK_HZ(128), .OFS_W(7)) i_rtc_offset_corrector (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .sec_start_i(sec_start),
        .sec_i(sec), .min_i(min), .hour_i(hour), .offset_i(offset),
        .mode_i(mode), .irq_en_i(irq_en),
        .add_req_o(add_req), .skip_req_o(skip_req), .corr_irq_o(corr_irq)
    );

    // {mode, offset[6:0]}
    localparam logic [7:0] VECS [14] = '{
        8'h01, 8'h44, 8'h3D, 8'h40, 8'h3F, 8'h7F, 8'h00,
        8'h85, 8'hC5, 8'hBC, 8'hBF, 8'hC0, 8'hBB, 8'h80
    };

    int checks = 0, errors = 0;
    int cur_idx = 0;
    int slot_add [120];
    int slot_skip [120];
    int tot_add = 0, tot_skip = 0, irq_rise = 0, irq_high = 0;
    logic irq_prev = 1'b0;
    bit done = 0;

    always @(negedge clk) begin
        if (add_req)  begin slot_add[cur_idx]++;  tot_add++;  end
        if (skip_req) begin slot_skip[cur_idx]++; tot_skip++; end
        if (corr_irq) irq_high++;
        if (corr_irq && !irq_prev) irq_rise++;
        irq_prev = corr_irq;
    end

    task automatic check_eq(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic step(int h, int m, int s, int idx);
        @(negedge clk);
        hour = 5'(h); min = 6'(m); sec = 6'(s);
        sec_start = 1'b1; cur_idx = idx;
        @(negedge clk) sec_start = 1'b0;
        repeat (8) tick_once();
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 120; i++) begin slot_add[i] = 0; slot_skip[i] = 0; end
        tot_add = 0; tot_skip = 0; irq_rise = 0; irq_high = 0;
    endtask

    // expected corrections in slot k of a burst run (R5..R8)
    function automatic int exp_slot(bit m, int n, int k);
        if (n == 0) return 0;
        if (!m) return (k < n) ? 1 : 0;
        if (k < 59) return (k < n) ? 1 : 0;
        if (k == 59) return (n >= 60) ? n - 59 : 0;
        return 0;
    endfunction

    function automatic string pat_tag(bit m, int n);
        if (n == 0) return "R3";
        if (!m) return (n <= 60) ? "R5" : "R6";
        return (n <= 60) ? "R7" : "R8";
    endfunction

    // mode 0: strobes at hour 2/3, second 0 of every minute
    // mode 1: strobes at minutes 4/5, every second
    task automatic run_burst(bit m, logic [6:0] off, bit ien, bit chg);
        @(negedge clk);
        mode = m; offset = off; irq_en = ien;
        clear_counts();
        for (int k = 0; k < 120; k++) begin
            if (!m) step(2 + k / 60, k % 60, 0, k);
            else    step(0, 4 + k / 60, k % 60, k);
            if (chg && k == 0) begin
                mode = !m; offset = 7'h6C;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_sim();
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; sec_start = 1'b0; mode = 1'b0; irq_en = 1'b0;
        sec = '0; min = '0; hour = '0; offset = '0;
        clear_counts();
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "add_req in reset", int'(add_req), 0);
        check_eq("R1", "skip_req in reset", int'(skip_req), 0);
        check_eq("R1", "corr_irq in reset", int'(corr_irq), 0);
        rst_n = 1'b1;
        repeat (4) tick_once();
        check_eq("R1", "requests after reset release", tot_add + tot_skip, 0);

        // R9 / R11: exact latency, mode 1, +1
        mode = 1'b1; offset = 7'd1; irq_en = 1'b1;
        @(negedge clk);
        hour = 0; min = 0; sec = 0; sec_start = 1'b1;
        @(negedge clk) sec_start = 1'b0;
        check_eq("R9", "add_req before tick", int'(add_req), 0);
        tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        check_eq("R9", "add_req cycle after tick", int'(add_req), 1);
        check_eq("R11", "irq with request", int'(corr_irq), 1);
        @(negedge clk);
        check_eq("R9", "add_req one cycle wide", int'(add_req), 0);
        check_eq("R11", "irq one cycle wide", int'(corr_irq), 0);
        repeat (4) tick_once();

        // R4: start points, mode 0
        irq_en = 1'b0; mode = 1'b0; offset = 7'd1;
        clear_counts();
        step(3, 0, 0, 0);
        check_eq("R4", "odd hour start", tot_add, 0);
        step(2, 1, 0, 0);
        check_eq("R4", "minute 1 start", tot_add, 0);
        step(2, 0, 5, 0);
        check_eq("R4", "second 5 start", tot_add, 0);
        step(2, 0, 0, 0);
        check_eq("R4", "even hour top start", tot_add, 1);
        // R4: start points, mode 1
        mode = 1'b1;
        clear_counts();
        step(0, 5, 0, 0);
        check_eq("R4", "minute 5 start", tot_add, 0);
        step(0, 8, 3, 0);
        check_eq("R4", "minute 8 second 3 start", tot_add, 0);
        step(0, 8, 0, 0);
        check_eq("R4", "minute 8 top start", tot_add, 1);

        // table of bursts
        for (int v = 0; v < 14; v++) begin
            logic signed [6:0] so;
            int sv, n, bad, first_bad, exp_a, exp_s;
            bit m;
            m = VECS[v][7];
            so = signed'(VECS[v][6:0]);
            sv = int'(so);
            n = (sv < 0) ? -sv : sv;
            run_burst(m, VECS[v][6:0], 1'b0, 1'b0);
            bad = 0; first_bad = -1;
            for (int k = 0; k < 120; k++) begin
                int e;
                e = exp_slot(m, n, k);
                if ((sv >= 0 ? slot_add[k] : slot_skip[k]) != e) begin
                    bad++;
                    if (first_bad < 0) first_bad = k;
                end
            end
            check_eq(pat_tag(m, n), $sformatf("slot mismatches mode %0d offset %0d (first %0d)",
                     m, sv, first_bad), bad, 0);
            exp_a = (sv > 0) ? n : 0;
            exp_s = (sv < 0) ? n : 0;
            check_eq("R2", $sformatf("add total mode %0d offset %0d", m, sv), tot_add, exp_a);
            check_eq("R2", $sformatf("skip total mode %0d offset %0d", m, sv), tot_skip, exp_s);
        end

        // R13: mid-burst change of offset and mode is ignored
        run_burst(1'b1, 7'd5, 1'b0, 1'b1);
        check_eq("R13", "add total after change", tot_add, 5);
        check_eq("R13", "skip total after change", tot_skip, 0);
        check_eq("R13", "second 4 still used", slot_add[4], 1);

        // R10: mode 0 interrupt width 2 ticks = 4 cycles each
        run_burst(1'b0, 7'd2, 1'b1, 1'b0);
        check_eq("R10", "irq pulses mode 0", irq_rise, 2);
        check_eq("R10", "irq high cycles mode 0", irq_high, 8);

        // R11: mode 1 interrupt one cycle per correction, drain included
        run_burst(1'b1, 7'h3F, 1'b1, 1'b0);
        check_eq("R11", "irq pulses mode 1", irq_rise, 63);
        check_eq("R11", "irq high cycles mode 1", irq_high, 63);

        // R12: interrupts disabled
        run_burst(1'b1, 7'd3, 1'b0, 1'b0);
        check_eq("R12", "irq pulses disabled", irq_rise, 0);
        check_eq("R12", "corrections still issued", tot_add, 3);

        finish_sim();
    end

endmodule